// File: doc/BRIEF.md
# User-Level Doorbell and Timestamp Register Window

This block is a small register window that user-level software can map straight into its address space. It sits on a plain 32-bit register bus with an address, a write enable with write data, and a read enable with registered read data. Only the low 16 bits of the address pick a register. The window is 64 KB in size and aligned to 64 KB. Every offset can be accessed without fault. An offset that decodes to nothing reads as zero and discards writes, and no access ever produces an error or a timeout.

The window holds four registers. The first is a fixed identification word. The next two expose a free-running nanosecond timestamp, split into a low word and a high word. The last is a write-only doorbell. The timestamp counts in 32 ns steps, one step for each cycle in which the tick input is high. It starts from a value presented on a preload port while reset is asserted.

Because the timestamp spans two words, software reads the high word, then the low word, then the high word again, and repeats the sequence if the two high values differ. A write to the doorbell passes the written word on as a channel number, together with a one-cycle strobe, to a pending-work tracker outside this block.

Top module: `user_reg_window`

## Requirements
- R1: While reset is low, the read data and the doorbell strobe are zero, and the timestamp takes the preload value with its five least significant bits cleared. After reset is released, the timestamp continues from that value.
- R2: A read of offset 0x0000 returns 50017 (0xC361) in bits 15:0, with all higher bits zero. The data appears on the clock edge that samples the read enable.
- R3: A read of offset 0x0080 returns timestamp bits 31:0. Bits 4:0 of this word are always zero, and the value is the one the timestamp held before that same edge.
- R4: A read of offset 0x0084 returns timestamp bits 60:32 in data bits 28:0. Data bits 31:29 are zero.
- R5: Each edge that samples tick high adds 32 to the 61-bit timestamp. An edge that samples tick low leaves the timestamp unchanged.
- R6: When the timestamp holds all ones in bits 60:5, one more tick wraps it to zero.
- R7: Every other word offset and every offset that is not word-aligned reads as zero. This includes 0x0004 to 0x007C, 0x0088 and 0x008C. Writes to those offsets, and writes to 0x0000, 0x0080 and 0x0084, change neither the timestamp nor the doorbell outputs.
- R8: A write to offset 0x0090 raises the doorbell strobe for exactly the following cycle, with the channel output equal to the written word. Back-to-back writes give back-to-back strobes. A read of 0x0090 returns zero.
- R9: Address bits 31:16 have no effect on decoding.
- R10: A cycle without a read enable leaves zero on the read data in the following cycle.
- R11: A carry from the low word into the high word between two reads of the high word shows up as two different high values. A retried high-low-high sequence with no carry in between returns the carried timestamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the timestamp from the preload port |
| tick_i | input | 1 | Advances the timestamp by one 32 ns step |
| preload_i | input | 61 | Starting timestamp, sampled while reset is low |
| addr_i | input | 32 | Byte address; only bits 15:0 are decoded |
| wr_en_i | input | 1 | Write enable |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read enable |
| rd_data_o | output | 32 | Registered read data, zero when no read was made |
| db_valid_o | output | 1 | One-cycle doorbell strobe |
| db_chan_o | output | 32 | Channel number of the latest doorbell write |

## Verification
The hardest case to reach is a carry from the low timestamp word into the high word that falls between two reads of the high word. With an arbitrary starting value this would take about 2^27 ticks. The bench instead resets the block with a preload whose low word is 0xFFFFFFE0. It reads the high word, then raises tick for the single edge that also samples the low-word read, and then reads the high word again. The two high values differ, and a retry must return the carried value. The wrap of the full 61-bit counter is reached the same way, by preloading all ones. Random traffic is then compared cycle by cycle against a behavioural model.

// File: rtl/uwin_pkg.sv
package uwin_pkg;

   localparam int unsigned WIN_BITS     = 16;
   localparam int unsigned OFF_IDENT    = 'h0000;
   localparam int unsigned OFF_TIME_LO  = 'h0080;
   localparam int unsigned OFF_TIME_HI  = 'h0084;
   localparam int unsigned OFF_DOORBELL = 'h0090;
   localparam logic [15:0] IDENT_CODE   = 16'd50017;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_IDENT,
      SEL_TIME_LO,
      SEL_TIME_HI,
      SEL_DOORBELL
   } reg_sel_e;

endpackage

// File: rtl/uwin_decode.sv
module uwin_decode
   import uwin_pkg::*;
#(
   parameter int unsigned WIN_W = uwin_pkg::WIN_BITS
) (
   input  logic [WIN_W-1:0] off_i,
   output reg_sel_e         sel_o
);

   if (WIN_W < 8) begin : g_err_win
      $error("uwin_decode: WIN_W too narrow for the register offsets");
   end

   always_comb begin
      if (off_i == WIN_W'(OFF_IDENT))              sel_o = SEL_IDENT;
      else if (off_i == WIN_W'(OFF_TIME_LO))       sel_o = SEL_TIME_LO;
      else if (off_i == WIN_W'(OFF_TIME_HI))       sel_o = SEL_TIME_HI;
      else if (off_i == WIN_W'(OFF_DOORBELL))      sel_o = SEL_DOORBELL;
      else                                         sel_o = SEL_NONE;
   end

endmodule

// File: rtl/uwin_timestamp.sv
module uwin_timestamp #(
   parameter int unsigned TS_W      = 61,
   parameter int unsigned GRAN_LOG2 = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic [TS_W-1:0] preload_i,
   output logic [TS_W-1:0] ns_o
);

   localparam int unsigned CNT_W = TS_W - GRAN_LOG2;

   if (GRAN_LOG2 >= TS_W) begin : g_err_gran
      $error("uwin_timestamp: GRAN_LOG2 must be below TS_W");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= preload_i[TS_W-1:GRAN_LOG2];
      else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
   end

   if (GRAN_LOG2 == 0) begin : g_fine
      assign ns_o = cnt_q;
   end else begin : g_coarse
      logic unused_preload_lsb;
      assign unused_preload_lsb = ^preload_i[GRAN_LOG2-1:0];
      assign ns_o = {cnt_q, {GRAN_LOG2{1'b0}}};
   end

endmodule

// File: rtl/uwin_doorbell.sv
module uwin_doorbell #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] chan_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         chan_o  <= '0;
      end else begin
         valid_o <= fire_i;
         if (fire_i) chan_o <= data_i;
      end
   end

endmodule

// File: rtl/user_reg_window.sv
module user_reg_window
   import uwin_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TS_W      = 61,
   parameter int unsigned GRAN_LOG2 = 5,
   parameter int unsigned WIN_W     = uwin_pkg::WIN_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [TS_W-1:0]   preload_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              db_valid_o,
   output logic [DATA_W-1:0] db_chan_o
);

   localparam int unsigned HI_W = TS_W - DATA_W;

   if (ADDR_W < WIN_W) begin : g_err_addr
      $error("user_reg_window: ADDR_W narrower than the window");
   end
   if (TS_W <= DATA_W || TS_W > 2 * DATA_W) begin : g_err_ts
      $error("user_reg_window: TS_W must span more than one and at most two words");
   end
   if (DATA_W < 16) begin : g_err_data
      $error("user_reg_window: DATA_W must hold the identification code");
   end

   if (ADDR_W > WIN_W) begin : g_upper_addr
      logic unused_upper_addr;
      assign unused_upper_addr = ^addr_i[ADDR_W-1:WIN_W];
   end

   reg_sel_e          sel;
   logic [TS_W-1:0]   ts_ns;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] rd_q;
   logic [HI_W-1:0]   ts_hi;

   uwin_decode #(.WIN_W(WIN_W)) u_decode (
      .off_i (addr_i[WIN_W-1:0]),
      .sel_o (sel)
   );

   uwin_timestamp #(.TS_W(TS_W), .GRAN_LOG2(GRAN_LOG2)) u_time (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .preload_i (preload_i),
      .ns_o      (ts_ns)
   );

   uwin_doorbell #(.DATA_W(DATA_W)) u_bell (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (wr_en_i && (sel == SEL_DOORBELL)),
      .data_i  (wr_data_i),
      .valid_o (db_valid_o),
      .chan_o  (db_chan_o)
   );

   assign ts_hi = ts_ns[TS_W-1:DATA_W];

   always_comb begin
      unique case (sel)
         SEL_IDENT:   rd_word = DATA_W'(IDENT_CODE);
         SEL_TIME_LO: rd_word = ts_ns[DATA_W-1:0];
         SEL_TIME_HI: rd_word = DATA_W'(ts_hi);
         default:     rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= rd_en_i ? rd_word : '0;
   end

   assign rd_data_o = rd_q;

endmodule

// File: rtl/uwin_checker.sv
module uwin_checker
   import uwin_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TS_W      = 61,
   parameter int unsigned GRAN_LOG2 = 5,
   parameter int unsigned WIN_W     = uwin_pkg::WIN_BITS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              wr_en_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic              rd_en_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              db_valid_o,
   input logic [DATA_W-1:0] db_chan_o,
   input logic [TS_W-1:0]   ns_i
);

   localparam logic [TS_W-1:0]   STEP     = TS_W'(1) << GRAN_LOG2;
   localparam logic [DATA_W-1:0] LSB_MASK = (DATA_W'(1) << GRAN_LOG2) - DATA_W'(1);

   logic [WIN_W-1:0] off;
   logic bell_wr, rd_id, rd_lo, rd_hi, rd_void;
   assign off     = addr_i[WIN_W-1:0];
   assign bell_wr = wr_en_i && (off == WIN_W'(OFF_DOORBELL));
   assign rd_id   = rd_en_i && (off == WIN_W'(OFF_IDENT));
   assign rd_lo   = rd_en_i && (off == WIN_W'(OFF_TIME_LO));
   assign rd_hi   = rd_en_i && (off == WIN_W'(OFF_TIME_HI));
   assign rd_void = rd_en_i && ((off == WIN_W'('h88)) || (off == WIN_W'('h8C)) ||
                                (off == WIN_W'(OFF_DOORBELL)));

   p_id_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_id |=> rd_data_o == DATA_W'(IDENT_CODE));

   p_lo_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> (rd_data_o == $past(ns_i[DATA_W-1:0])) && ((rd_data_o & LSB_MASK) == '0));

   p_hi_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi |=> (rd_data_o >> (TS_W - DATA_W)) == '0);

   p_tick_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> ns_i == $past(ns_i) + STEP);

   p_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(ns_i));

   p_void_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_void |=> rd_data_o == '0);

   p_bell_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bell_wr |=> !db_valid_o);

   p_bell_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bell_wr |=> db_valid_o && (db_chan_o == $past(wr_data_i)));

   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> rd_data_o == '0);

endmodule

bind user_reg_window uwin_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TS_W(TS_W), .GRAN_LOG2(GRAN_LOG2), .WIN_W(WIN_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_i     (tick_i),
   .addr_i     (addr_i),
   .wr_en_i    (wr_en_i),
   .wr_data_i  (wr_data_i),
   .rd_en_i    (rd_en_i),
   .rd_data_o  (rd_data_o),
   .db_valid_o (db_valid_o),
   .db_chan_o  (db_chan_o),
   .ns_i       (ts_ns)
);

// File: tb/tb_user_reg_window.sv
module tb_user_reg_window;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic [60:0] preload_i = '0;
   logic [31:0] addr_i = '0;
   logic        wr_en_i = 1'b0;
   logic [31:0] wr_data_i = '0;
   logic        rd_en_i = 1'b0;
   logic [31:0] rd_data_o;
   logic        db_valid_o;
   logic [31:0] db_chan_o;

   always #10 clk = ~clk;

   user_reg_window dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .preload_i(preload_i),
      .addr_i(addr_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
      .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
      .db_valid_o(db_valid_o), .db_chan_o(db_chan_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   localparam logic [63:0] MASK61 = (64'd1 << 61) - 64'd1;
   logic [63:0] m_ns = '0;
   logic [31:0] e_rd = '0;
   logic        e_db = 1'b0;
   logic [31:0] e_chan = '0;
   string       e_tag = "R1";
   bit          model_on = 1'b0;

   always @(posedge clk) begin
      int off;
      model_on = 1'b1;
      if (!rst_n) begin
         m_ns   = {3'b0, preload_i} & ~64'd31;
         e_rd   = '0;
         e_db   = 1'b0;
         e_chan = '0;
         e_tag  = "R1";
      end else begin
         off = int'(addr_i[15:0]);
         e_rd = '0;
         if (!rd_en_i) e_tag = "R10";
         else if (off == 0)      begin e_rd = 32'd50017;      e_tag = "R2"; end
         else if (off == 'h80)   begin e_rd = m_ns[31:0];     e_tag = "R3"; end
         else if (off == 'h84)   begin e_rd = m_ns[63:32];    e_tag = "R4"; end
         else if (off == 'h90)   e_tag = "R8";
         else                    e_tag = "R7";
         if (addr_i[31:16] != 0 && rd_en_i) e_tag = "R9";
         e_db = wr_en_i && (off == 'h90);
         if (e_db) e_chan = wr_data_i;
         if (tick_i) m_ns = (m_ns + 64'd32) & MASK61;
      end
   end

   always @(negedge clk) begin
      if (model_on && !done) begin
         check({e_tag, " read data"}, {32'd0, rd_data_o}, {32'd0, e_rd});
         check(e_db ? "R8 strobe" : "R7 strobe", {63'd0, db_valid_o}, {63'd0, e_db});
         if (e_db) check("R8 channel", {32'd0, db_chan_o}, {32'd0, e_chan});
      end
   end

   // ---------------- stimulus helpers (called at a negedge) ----------------
   task automatic do_read(input logic [31:0] a, output logic [31:0] d);
      rd_en_i = 1'b1;
      addr_i  = a;
      @(negedge clk);
      d = rd_data_o;
      rd_en_i = 1'b0;
   endtask

   task automatic do_write(input logic [31:0] a, input logic [31:0] v);
      wr_en_i   = 1'b1;
      addr_i    = a;
      wr_data_i = v;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic do_reset(input logic [60:0] p);
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      preload_i = p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   localparam logic [60:0] P0 = 61'h1ABC_DEF0_1234_5678;

   initial begin
      logic [31:0] d, lo1, lo2, h1, h2;
      int tries;
      bit matched;
      preload_i = P0;
      repeat (3) @(negedge clk);
      check("R1 read data in reset", {32'd0, rd_data_o}, 64'd0);
      check("R1 strobe in reset", {63'd0, db_valid_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      do_read(32'h0000_0080, d);
      check("R1 low word from preload", {32'd0, d}, {32'd0, P0[31:0] & ~32'd31});
      do_read(32'h0000_0084, d);
      check("R1 high word from preload", {32'd0, d}, {35'd0, P0[60:32]});
      do_read(32'h0000_0000, d);
      check("R2 identification", {32'd0, d}, 64'd50017);
      do_read(32'hFFFF_0000, d);
      check("R9 upper bits ignored", {32'd0, d}, 64'd50017);

      do_read(32'h0000_0080, lo1);
      tick_i = 1'b1;
      repeat (5) @(negedge clk);
      tick_i = 1'b0;
      repeat (3) @(negedge clk);
      do_read(32'h0000_0080, lo2);
      check("R5 five ticks", {32'd0, lo2}, {32'd0, lo1 + 32'd160});

      foreach (d[i]) begin end
      do_read(32'h0000_0004, d); check("R7 offset 0x04", {32'd0, d}, 64'd0);
      do_read(32'h0000_007C, d); check("R7 offset 0x7C", {32'd0, d}, 64'd0);
      do_read(32'h0000_0088, d); check("R7 offset 0x88", {32'd0, d}, 64'd0);
      do_read(32'h0000_008C, d); check("R7 offset 0x8C", {32'd0, d}, 64'd0);
      do_read(32'h0000_0082, d); check("R7 unaligned", {32'd0, d}, 64'd0);
      do_read(32'h0000_0090, d); check("R8 read of doorbell", {32'd0, d}, 64'd0);

      do_write(32'h0000_0080, 32'h0);
      do_write(32'h0000_0084, 32'hFFFF_FFFF);
      do_write(32'h0000_0000, 32'h1);
      do_write(32'h0000_0088, 32'h55);
      do_write(32'h0000_0094, 32'h66);
      do_read(32'h0000_0080, d);
      check("R7 writes leave timestamp", {32'd0, d}, {32'd0, lo2});
      check("R7 no doorbell after writes", {63'd0, db_valid_o}, 64'd0);

      do_write(32'h0000_0090, 32'hDEAD_BEEF);
      check("R8 strobe high", {63'd0, db_valid_o}, 64'd1);
      check("R8 channel value", {32'd0, db_chan_o}, 64'hDEAD_BEEF);
      @(negedge clk);
      check("R8 strobe one cycle", {63'd0, db_valid_o}, 64'd0);
      do_write(32'h0000_0090, 32'd7);
      do_write(32'h1234_0090, 32'd8);
      check("R9 doorbell via upper address", {32'd0, db_chan_o}, 64'd8);

      for (int k = 0; k < 400; k++) begin
         logic [31:0] a;
         case ($urandom % 9)
            0: a = 32'h0000_0000;
            1: a = 32'h0000_0080;
            2: a = 32'h0000_0084;
            3: a = 32'h0000_0090;
            4: a = 32'h0000_0088;
            5: a = 32'h0000_008C;
            6: a = {$urandom} & 32'h0000_FFFF;
            7: a = 32'hA5A5_0080;
            default: a = 32'h0000_0084;
         endcase
         addr_i    = a;
         rd_en_i   = $urandom % 2 == 0;
         wr_en_i   = $urandom % 3 == 0;
         wr_data_i = $urandom;
         tick_i    = $urandom % 2 == 0;
         @(negedge clk);
      end
      rd_en_i = 1'b0; wr_en_i = 1'b0; tick_i = 1'b0;

      // R11: carry between the two high-word reads, then a clean retry
      do_reset({29'h0ABC_DEF, 32'hFFFF_FFE0});
      do_read(32'h0000_0084, h1);
      tick_i = 1'b1;
      do_read(32'h0000_0080, lo1);
      tick_i = 1'b0;
      do_read(32'h0000_0084, h2);
      check("R11 low word before carry", {32'd0, lo1}, 64'hFFFF_FFE0);
      check("R11 mismatch detected", {63'd0, h1 != h2}, 64'd1);
      matched = 1'b0;
      tries = 0;
      while (!matched && tries < 4) begin
         tries++;
         do_read(32'h0000_0084, h1);
         do_read(32'h0000_0080, lo1);
         do_read(32'h0000_0084, h2);
         matched = (h1 == h2);
      end
      check("R11 retry value", {h1, lo1}, {32'h0ABC_DF0, 32'h0});

      // R6: full wrap
      do_reset({61{1'b1}});
      do_read(32'h0000_0084, d);
      check("R6 high before wrap", {32'd0, d}, 64'h1FFF_FFFF);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      do_read(32'h0000_0080, d);
      check("R6 low after wrap", {32'd0, d}, 64'd0);
      do_read(32'h0000_0084, d);
      check("R6 high after wrap", {32'd0, d}, 64'd0);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule